// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR flash and turns single read requests into flash read cycles. A request carries a byte address and a flag that selects 16-bit or 8-bit transfers. The controller drives chip enable, output enable, write enable, the word address and the byte-mode pin. It samples the flash data lines after a wait counted in clock cycles and returns the result with a one-cycle valid strobe.

Chip enable stays low after a read, so the page of eight words that was just read stays open. The next request that falls in the same page and uses the same transfer width waits only the short intra-page time. Any other request releases chip enable for one setup cycle and then waits the full random access time. An idle timeout also releases chip enable. Any release forgets the open page.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: After a synchronous active-high reset, chip enable and output enable are high, `rsp_valid` is low, `req_ready` is high, the byte-mode pin is high (word mode) and no page is open, so the first read after reset waits the full time even if it falls in a page that was being read when reset came.
- R2: Write enable is always high. While chip enable is low, output enable is also low.
- R3: The flash address and byte-mode pin are held for at least one cycle with chip enable high before chip enable falls.
- R4: A request that opens a page is accepted on one clock edge and raises `rsp_valid` on edge FULL_WAIT+1 after it. One setup cycle has chip enable high, then FULL_WAIT cycles have it low.
- R5: A request whose address bits [AW:4] match the open page and whose mode flag matches raises `rsp_valid` on edge PAGE_WAIT after acceptance, and chip enable stays low throughout.
- R6: A request for a different page while a page is open makes chip enable rise for exactly one cycle and then waits the full time of R4.
- R7: In byte mode (`req_byte`=1) the byte-mode pin is low, `fl_dq15_oe` is high, `fl_dq15_out` carries `req_addr[0]`, and `rsp_data` is {8'h00, `fl_dq_in[7:0]`}. In word mode the byte-mode pin is high, `fl_dq15_oe` is low, and `rsp_data` is all 16 bits of `fl_dq_in`.
- R8: `fl_addr` equals `req_addr[AW:1]` of the accepted request from the edge after acceptance until the next acceptance.
- R9: If no request is accepted for IDLE_LIMIT consecutive edges while a page is open, chip enable rises on the IDLE_LIMIT-th edge. The next request then waits the full time.
- R10: A request whose mode flag differs from the open page's mode counts as a miss, even when its page bits match.
- R11: `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` is low from acceptance until that cycle.
- R12: If a same-page request is accepted on the edge where the idle timeout would expire, the request takes priority and is served as a page hit with chip enable kept low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | AW+1 | Byte address; bit 0 selects the byte in byte mode |
| req_byte | input | 1 | 1 = 8-bit transfer, 0 = 16-bit transfer |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_data | output | 16 | Returned data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low (held high) |
| fl_addr | output | AW | Flash word address |
| fl_byte_n | output | 1 | Flash width select, 1 = word, 0 = byte |
| fl_dq15_out | output | 1 | Lowest byte address bit for the DQ15 pin in byte mode |
| fl_dq15_oe | output | 1 | Drive enable for the DQ15 pin |
| fl_dq_in | input | 16 | Flash data lines |

## Verification
The idle timeout and the acceptance of a same-page request can fall on the same clock edge. The bench waits for a response and then holds off exactly IDLE_LIMIT-1 cycles. It presents a request to the open page so that it is accepted on the very edge where the timeout would expire. It then checks that the latency is PAGE_WAIT, not FULL_WAIT+1, and that chip enable never rose. A separate run with no request checks that chip enable is still low after IDLE_LIMIT-1 edges and is high after the IDLE_LIMIT-th edge.

// File: rtl/pflash_pkg.sv
`timescale 1ns/1ps
package pflash_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_OPEN  = 2'd3
  } rd_state_e;

  // Counter preload for an access: the wait ends when the counter reaches zero.
  function automatic int unsigned wait_preload(input logic hit,
                                               input int unsigned full_w,
                                               input int unsigned page_w);
    return hit ? (page_w - 1) : (full_w - 1);
  endfunction

  // Shape the flash data lines into the returned word.
  function automatic logic [15:0] shape_data(input logic byte_mode,
                                             input logic [15:0] dq);
    return byte_mode ? {8'h00, dq[7:0]} : dq;
  endfunction

endpackage

// File: rtl/pflash_page_track.sv
`timescale 1ns/1ps
module pflash_page_track #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_mode,
  output logic             hit
);
  logic [TAG_W-1:0] tag_q;
  logic             mode_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      mode_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (load) begin
      tag_q  <= req_tag;
      mode_q <= req_mode;
      vld_q  <= 1'b1;
    end else if (clear) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit = vld_q && (tag_q == req_tag) && (mode_q == req_mode);
endmodule

// File: rtl/pflash_wait_timer.sv
`timescale 1ns/1ps
module pflash_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pflash_idle_timer.sv
`timescale 1ns/1ps
module pflash_idle_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int IW = $clog2(LIMIT + 1);
  localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || kick) cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !kick && (cnt_q == LAST);
endmodule

// File: rtl/pflash_rd_ctrl.sv
`timescale 1ns/1ps
module pflash_rd_ctrl #(
  parameter int AW         = 23,
  parameter int FULL_WAIT  = 6,
  parameter int PAGE_WAIT  = 2,
  parameter int IDLE_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW:0]   req_addr,
  input  logic          req_byte,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic          fl_byte_n,
  output logic          fl_dq15_out,
  output logic          fl_dq15_oe,
  input  logic [15:0]   fl_dq_in
);
  import pflash_pkg::*;

  localparam int TAG_W = AW - 3;
  localparam int MAXW  = (FULL_WAIT > PAGE_WAIT) ? FULL_WAIT : PAGE_WAIT;
  localparam int CW    = $clog2(MAXW + 1);

  rd_state_e state_q, state_d;

  // Named internal events, also observed by the bound checker.
  logic accept;
  logic page_hit;
  logic idle_expire;
  logic wait_done;
  logic timer_load;
  logic [CW-1:0] timer_val;

  logic [AW-1:0] addr_q;
  logic          a_m1_q;
  logic          byte_q;
  logic          rsp_valid_q;
  logic [15:0]   rsp_data_q;

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_OPEN);
  assign accept    = req_valid && req_ready;

  pflash_page_track #(.TAG_W(TAG_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .clear    (idle_expire),
    .req_tag  (req_addr[AW:4]),
    .req_mode (req_byte),
    .hit      (page_hit)
  );

  pflash_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .run    (state_q == ST_OPEN),
    .kick   (accept),
    .expire (idle_expire)
  );

  // The timer is preloaded for a full access when setup ends,
  // or for a short access when a page hit is accepted.
  always_comb begin
    timer_load = 1'b0;
    timer_val  = '0;
    if (state_q == ST_SETUP) begin
      timer_load = 1'b1;
      timer_val  = CW'(wait_preload(1'b0, FULL_WAIT, PAGE_WAIT));
    end else if (state_q == ST_OPEN && accept && page_hit) begin
      timer_load = 1'b1;
      timer_val  = CW'(wait_preload(1'b1, FULL_WAIT, PAGE_WAIT));
    end
  end

  pflash_wait_timer #(.CW(CW)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .zero     (wait_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_WAIT;
      ST_WAIT:  if (wait_done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (accept)           state_d = page_hit ? ST_WAIT : ST_SETUP;
        else if (idle_expire) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      a_m1_q      <= 1'b0;
      byte_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      if (accept) begin
        addr_q <= req_addr[AW:1];
        a_m1_q <= req_addr[0];
        byte_q <= req_byte;
      end
      if (state_q == ST_WAIT && wait_done) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= shape_data(byte_q, fl_dq_in);
      end
    end
  end

  assign fl_ce_n     = !((state_q == ST_WAIT) || (state_q == ST_OPEN));
  assign fl_oe_n     = fl_ce_n;
  assign fl_we_n     = 1'b1;
  assign fl_addr     = addr_q;
  assign fl_byte_n   = !byte_q;
  assign fl_dq15_oe  = byte_q;
  assign fl_dq15_out = byte_q & a_m1_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
endmodule

// File: rtl/pflash_rd_ctrl_chk.sv
`timescale 1ns/1ps
module pflash_rd_ctrl_chk #(
  parameter int AW = 23
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n,
  input logic [AW-1:0] fl_addr,
  input logic          fl_byte_n,
  input logic          accept,
  input logic          page_hit,
  input logic          idle_expire
);
  // R1: reset leaves the bus released and the request side ready
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (fl_ce_n && fl_oe_n && !rsp_valid && req_ready));

  // R2: an active cycle never drives write enable and always enables outputs
  p_read_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    !fl_ce_n |-> (fl_we_n && !fl_oe_n));

  // R3: address and width pin are steady across the chip-enable fall
  p_addr_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_ce_n) |-> ($stable(fl_addr) && $stable(fl_byte_n)));

  // R5: a hit keeps chip enable low
  p_hit_keeps_ce_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && page_hit && !fl_ce_n) |=> !fl_ce_n);

  // R6: a miss on an open page releases chip enable for setup
  p_miss_release_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && !page_hit) |=> fl_ce_n);

  // R9: idle timeout releases chip enable
  p_idle_release_r9: assert property (@(posedge clk) disable iff (rst)
    idle_expire |=> fl_ce_n);

  // R11: response strobe lasts one cycle
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R11: no second request is taken while an access is running
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R12: a request and a timeout never both act on one edge
  p_req_beats_timeout_r12: assert property (@(posedge clk) disable iff (rst)
    !(accept && idle_expire));
endmodule

bind pflash_rd_ctrl pflash_rd_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .fl_ce_n     (fl_ce_n),
  .fl_oe_n     (fl_oe_n),
  .fl_we_n     (fl_we_n),
  .fl_addr     (fl_addr),
  .fl_byte_n   (fl_byte_n),
  .accept      (accept),
  .page_hit    (page_hit),
  .idle_expire (idle_expire)
);

// File: tb/pflash_rd_ctrl_test.sv
`timescale 1ns/1ps
module pflash_rd_ctrl_test;
  localparam int AW = 23;
  localparam int FW = 6;
  localparam int PW = 2;
  localparam int IL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW:0]   req_addr = '0;
  logic          req_byte = 1'b0;
  logic          rsp_valid;
  logic [15:0]   rsp_data;
  logic          fl_ce_n, fl_oe_n, fl_we_n;
  logic [AW-1:0] fl_addr;
  logic          fl_byte_n, fl_dq15_out, fl_dq15_oe;
  logic [15:0]   fl_dq_in;

  pflash_rd_ctrl #(.AW(AW), .FULL_WAIT(FW), .PAGE_WAIT(PW), .IDLE_LIMIT(IL)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_byte_n(fl_byte_n),
    .fl_dq15_out(fl_dq15_out), .fl_dq15_oe(fl_dq15_oe), .fl_dq_in(fl_dq_in)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Flash content: a word is a function of its word address.
  function automatic logic [15:0] word_at(input logic [AW-1:0] wa);
    return {wa[7:0] ^ 8'h3C, wa[15:8] ^ wa[7:0]};
  endfunction

  function automatic logic [15:0] expect_data(input logic [AW:0] a, input logic b);
    logic [15:0] w;
    w = word_at(a[AW:1]);
    if (!b) return w;
    return {8'h00, (a[0] ? w[15:8] : w[7:0])};
  endfunction

  // Flash model: data only while both enables are low.
  always_comb begin
    logic [15:0] w;
    w = word_at(fl_addr);
    if (fl_ce_n || fl_oe_n)  fl_dq_in = 16'hDEAD;
    else if (!fl_byte_n)     fl_dq_in = {8'hEE, (fl_dq15_out ? w[15:8] : w[7:0])};
    else                     fl_dq_in = w;
  end

  // Port monitors sampled at the falling edge.
  int   ce_rises = 0;
  int   pulse_bad = 0;
  int   busy_bad = 0;
  logic ce_prev = 1'b1;
  logic rsp_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (fl_ce_n && !ce_prev) ce_rises++;
      if (rsp_valid && rsp_prev) pulse_bad++;
    end
    ce_prev  = fl_ce_n;
    rsp_prev = rsp_valid;
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [AW:0] a, input logic b, input int pre,
                       output int lat, output logic [15:0] d, output int rises);
    int r0;
    repeat (pre) @(negedge clk);
    req_addr  = a;
    req_byte  = b;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    r0 = ce_rises;
    @(posedge clk);
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid || lat > 1000) break;
      if (req_ready) busy_bad++;
    end
    d     = rsp_data;
    rises = ce_rises - r0;
  endtask

  // {byte_mode, expect_hit, byte_address}
  localparam logic [25:0] VEC [10] = '{
    {1'b0, 1'b0, 24'h000010},
    {1'b0, 1'b1, 24'h00001E},
    {1'b0, 1'b1, 24'h000012},
    {1'b1, 1'b0, 24'h000013},
    {1'b1, 1'b1, 24'h00001C},
    {1'b1, 1'b0, 24'h000020},
    {1'b1, 1'b1, 24'h00002F},
    {1'b0, 1'b0, 24'h00002F},
    {1'b0, 1'b0, 24'h123450},
    {1'b0, 1'b1, 24'h12345E}
  };

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, rises, exp_lat;
    logic [15:0] d;
    string tg;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(fl_ce_n && fl_oe_n, "R1 enables", {fl_ce_n, fl_oe_n}, 2'b11);
    check(!rsp_valid && req_ready, "R1 handshake", {rsp_valid, req_ready}, 2'b01);
    check(fl_byte_n == 1'b1, "R1 width pin", fl_byte_n, 1);
    check(fl_we_n == 1'b1, "R2 write enable", fl_we_n, 1);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      logic [25:0] v;
      v = VEC[i];
      tg = v[24] ? "R5" : ((i == 3 || i == 7) ? "R10" : ((i == 0) ? "R4" : "R6"));
      issue(v[AW:0], v[25], 1, lat, d, rises);
      exp_lat = v[24] ? PW : FW + 1;
      check(lat == exp_lat, {tg, " latency"}, lat, exp_lat);
      check(d == expect_data(v[AW:0], v[25]), "R7 data", d, expect_data(v[AW:0], v[25]));
      check(fl_addr == v[AW:1], "R8 word address", fl_addr, v[AW:1]);
      check(fl_byte_n == !v[25], "R7 width pin", fl_byte_n, !v[25]);
      check(fl_dq15_oe == v[25], "R7 dq15 enable", fl_dq15_oe, v[25]);
      if (v[25]) check(fl_dq15_out == v[0], "R7 dq15 bit", fl_dq15_out, v[0]);
      check(!fl_ce_n && !fl_oe_n && fl_we_n, "R2 strobes open",
            {fl_ce_n, fl_oe_n, fl_we_n}, 3'b001);
      if (v[24])      check(rises == 0, "R5 chip enable held", rises, 0);
      else if (i > 0) check(rises == 1, {tg, " chip enable release"}, rises, 1);
    end

    // R9: timeout after IL idle edges, then full wait
    repeat (IL - 1) @(negedge clk);
    check(fl_ce_n == 1'b0, "R9 still open", fl_ce_n, 0);
    @(negedge clk);
    check(fl_ce_n == 1'b1, "R9 released", fl_ce_n, 1);
    issue(24'h123452, 1'b0, 1, lat, d, rises);
    check(lat == FW + 1, "R9 full wait after timeout", lat, FW + 1);

    // R12: same-page request accepted on the expiry edge
    issue(24'h123454, 1'b0, IL - 1, lat, d, rises);
    check(lat == PW, "R12 served as hit", lat, PW);
    check(rises == 0, "R12 chip enable held", rises, 0);
    check(d == expect_data(24'h123454, 1'b0), "R12 data", d, expect_data(24'h123454, 1'b0));

    // R11 handshake and pulse width over the whole run
    check(pulse_bad == 0, "R11 strobe width", pulse_bad, 0);
    check(busy_bad == 0, "R11 ready during access", busy_bad, 0);

    // R1: reset in the middle of an access
    @(negedge clk);
    req_addr = 24'h000100; req_byte = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(fl_ce_n == 1'b0, "R4 access running", fl_ce_n, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(fl_ce_n && !rsp_valid && req_ready, "R1 reset mid access",
          {fl_ce_n, rsp_valid, req_ready}, 3'b101);
    issue(24'h000102, 1'b0, 1, lat, d, rises);
    check(lat == FW + 1, "R1 page forgotten", lat, FW + 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule